// File: doc/BRIEF.md
# Flash Command Register Decoder

This block is the bus-side command front end of a byte-wide electrically erasable memory. A fast system clock samples the active-low chip select, output enable and write strobe as synchronous inputs. The block finds write cycles in them, keeps the address and data that each write carries, and interprets the written byte as a command. Single-cycle commands choose what a read returns: array data or the two identifier bytes. Two-cycle commands (program, bulk erase) produce a one-clock start request to an external program/erase sequencer. The request carries the operation kind and the latched target address and data.

The command path only works while `hv_en` reports the high-voltage supply present and `lockout` reports the logic supply healthy. Otherwise the register stays in read-array mode and every write is dropped. While a program or erase runs, further writes have no effect. The `seq_done` pulse from the sequencer returns the block to read-array mode. The memory array and the sequencer are outside this block. The system reads the array or `id_byte` according to `rd_id_sel`.

Top module: `flash_cmd_if`

## Requirements
- R1: A write cycle exists only while `ce_n`=0, `we_n`=0 and `oe_n`=1 are sampled together; a strobe given while `oe_n`=0 changes no mode.
- R2: The address of a write is the `addr` value on the first clock where the write condition holds, i.e. at the later of the two falling strobes.
- R3: The data of a write is the `din` value on the last clock where the write condition holds, i.e. just before the earlier of the two rising strobes.
- R4: A write condition lasting fewer than `MIN_PULSE` clocks (default 2) is discarded; one lasting `MIN_PULSE` clocks is accepted.
- R5: After reset, and after writing 00h or FFh, the block is in read-array mode (`rd_id_sel`=0) and stays there until another command is written.
- R6: Writing 80h or 90h selects identifier mode (`rd_id_sel`=1); in that mode `id_byte` is 01h when `addr[0]`=0 and 2Fh when `addr[0]`=1.
- R7: Writing 30h and then 30h gives a single-clock `seq_start` with `seq_kind`=1 (erase); the first 30h alone starts nothing.
- R8: Writing 10h or 50h and then any byte gives a single-clock `seq_start` with `seq_kind`=0 (program), with `lat_addr`/`lat_data` equal to the address and data of the second write.
- R9: After 30h, a second write other than 30h abandons the sequence with no start and leaves read-array mode, so a following single 30h starts nothing.
- R10: While `hv_en`=0 the block is forced to read-array mode within one clock and ignores writes; a half-entered sequence is lost.
- R11: While `lockout`=1 the block is forced to read-array mode within one clock and ignores writes, including an operation in progress; writes take effect again once it clears.
- R12: From a start until `seq_done`, writes are ignored; `seq_done` returns the block to read-array mode, after which commands are accepted again.
- R13: A written byte that is not a recognised command puts the block in read-array mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Bus address |
| din | input | 8 | Bus write data |
| hv_en | input | 1 | High-voltage supply present; 0 locks the command path |
| lockout | input | 1 | Low logic-supply indication; 1 clears and locks the command path |
| seq_done | input | 1 | Sequencer finished its operation (one-clock pulse) |
| rd_id_sel | output | 1 | Read mux select: 1 = identifier bytes, 0 = array |
| id_byte | output | 8 | Identifier byte for the current address |
| seq_start | output | 1 | One-clock start request to the sequencer |
| seq_kind | output | 1 | Operation kind of the request: 0 program, 1 erase |
| lat_addr | output | AW | Latched target address of the request |
| lat_data | output | 8 | Latched data of the request |

## Verification
The bench drives a write controlled by chip select while the write strobe is already low. It moves the address after the cycle opens and the data just before it closes. A design that latched on the wrong edge would report a neighbouring address or a stale data byte in `lat_addr`/`lat_data`. Pulses of one clock and of exactly the minimum width are tried; an off-by-one filter either lets glitches through or drops legal writes. The tests also abandon an erase sequence half-way and pull the high-voltage enable or the lockout while a sequence is armed or running. An FSM that kept its armed or busy state across these events would start an erase from a single 30h, or would ignore commands long after the operation ended.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_ARRAY     = 3'd0,
        ST_IDENT     = 3'd1,
        ST_ERASE_ARM = 3'd2,
        ST_PROG_ARM  = 3'd3,
        ST_BUSY      = 3'd4
    } cmd_state_e;

    typedef enum logic {
        KIND_PROG  = 1'b0,
        KIND_ERASE = 1'b1
    } seq_kind_e;

    localparam logic [7:0] OP_READ_LO  = 8'h00;
    localparam logic [7:0] OP_READ_HI  = 8'hFF;
    localparam logic [7:0] OP_IDENT_LO = 8'h80;
    localparam logic [7:0] OP_IDENT_HI = 8'h90;
    localparam logic [7:0] OP_ERASE    = 8'h30;
    localparam logic [7:0] OP_PROG_LO  = 8'h10;
    localparam logic [7:0] OP_PROG_HI  = 8'h50;

    localparam logic [7:0] IDENT_MAKER  = 8'h01;
    localparam logic [7:0] IDENT_DEVICE = 8'h2F;

    // Decode a first-cycle command byte to the next register state.
    function automatic cmd_state_e decode_first(input logic [7:0] op);
        cmd_state_e r;
        unique case (op)
            OP_IDENT_LO, OP_IDENT_HI: r = ST_IDENT;
            OP_ERASE:                 r = ST_ERASE_ARM;
            OP_PROG_LO, OP_PROG_HI:   r = ST_PROG_ARM;
            default:                  r = ST_ARRAY;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/flash_wr_detect.sv
module flash_wr_detect #(
    parameter int AW        = 15,
    parameter int MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    localparam int CW = $clog2(MIN_PULSE + 1);
    localparam logic [CW-1:0] CNT_MIN = CW'(MIN_PULSE);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
        logic [AW-1:0] a;
        logic [7:0]    d;
        logic          stb;
    } det_t;

    det_t det_d, det_q;
    logic act_now;

    always_comb begin
        act_now = ~ce_n & ~we_n & oe_n;
        det_d     = det_q;
        det_d.stb = 1'b0;
        det_d.act = act_now;
        if (act_now && !det_q.act) begin
            // opening edge: the later of the two falling strobes
            det_d.a   = addr;
            det_d.d   = din;
            det_d.cnt = CNT_ONE;
        end else if (act_now) begin
            det_d.d = din;
            if (det_q.cnt < CNT_MIN) begin
                det_d.cnt = det_q.cnt + CNT_ONE;
            end
        end else if (det_q.act) begin
            // closing edge: the earlier rising strobe ends the cycle
            det_d.stb = (det_q.cnt >= CNT_MIN);
            det_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign wr_stb  = det_q.stb;
    assign wr_addr = det_q.a;
    assign wr_data = det_q.d;

    // R2: the captured address does not move while the cycle stays open
    a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q.act && act_now) |=> $stable(wr_addr));

    // R4: a cycle closing before the minimum width yields no strobe
    a_r4_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q.act && !act_now && (det_q.cnt < CNT_MIN)) |=> !wr_stb);

    // R1: one strobe per write cycle
    a_r1_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom
    import flash_cmd_pkg::*;
(
    input  logic       sel_dev,
    output logic [7:0] id_byte
);

    always_comb begin
        id_byte = sel_dev ? IDENT_DEVICE : IDENT_MAKER;
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hv_en,
    input  logic          lockout,
    input  logic          seq_done,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    output logic          rd_id_sel,
    output logic          seq_start,
    output logic          seq_kind,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data
);

    typedef struct packed {
        cmd_state_e    st;
        logic          start;
        seq_kind_e     kind;
        logic [AW-1:0] la;
        logic [7:0]    ld;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d       = fsm_q;
        fsm_d.start = 1'b0;
        if (!hv_en || lockout) begin
            fsm_d.st = ST_ARRAY;
        end else begin
            unique case (fsm_q.st)
                ST_BUSY: begin
                    if (seq_done) begin
                        fsm_d.st = ST_ARRAY;
                    end
                end
                ST_ERASE_ARM: begin
                    if (wr_stb) begin
                        if (wr_data == OP_ERASE) begin
                            fsm_d.st    = ST_BUSY;
                            fsm_d.start = 1'b1;
                            fsm_d.kind  = KIND_ERASE;
                            fsm_d.la    = wr_addr;
                            fsm_d.ld    = wr_data;
                        end else begin
                            fsm_d.st = ST_ARRAY;
                        end
                    end
                end
                ST_PROG_ARM: begin
                    if (wr_stb) begin
                        fsm_d.st    = ST_BUSY;
                        fsm_d.start = 1'b1;
                        fsm_d.kind  = KIND_PROG;
                        fsm_d.la    = wr_addr;
                        fsm_d.ld    = wr_data;
                    end
                end
                default: begin
                    if (wr_stb) begin
                        fsm_d.st = decode_first(wr_data);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_ARRAY, start: 1'b0, kind: KIND_PROG, la: '0, ld: '0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign rd_id_sel = (fsm_q.st == ST_IDENT);
    assign seq_start = fsm_q.start;
    assign seq_kind  = fsm_q.kind;
    assign lat_addr  = fsm_q.la;
    assign lat_data  = fsm_q.ld;

    // R10: no high voltage means read-array mode and no start next clock
    a_r10_hv_off: assert property (@(posedge clk) disable iff (!rst_n)
        !hv_en |=> (!seq_start && !rd_id_sel));

    // R11: lockout forces read-array mode and blocks starts
    a_r11_lockout: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (!seq_start && !rd_id_sel));

    // R7: the start request lasts one clock
    a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |=> !seq_start);

    // R8: a start always follows an accepted write strobe
    a_r8_start_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        seq_start |-> $past(wr_stb));

    // R8: latched target only changes together with a start
    a_r8_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_start |-> ($stable(lat_addr) && $stable(lat_data)));

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
    parameter int AW        = 15,
    parameter int MIN_PULSE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          hv_en,
    input  logic          lockout,
    input  logic          seq_done,
    output logic          rd_id_sel,
    output logic [7:0]    id_byte,
    output logic          seq_start,
    output logic          seq_kind,
    output logic [AW-1:0] lat_addr,
    output logic [7:0]    lat_data
);

    logic          wr_stb;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;

    flash_wr_detect #(
        .AW        (AW),
        .MIN_PULSE (MIN_PULSE)
    ) i_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_cmd_fsm #(
        .AW (AW)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hv_en     (hv_en),
        .lockout   (lockout),
        .seq_done  (seq_done),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_id_sel (rd_id_sel),
        .seq_start (seq_start),
        .seq_kind  (seq_kind),
        .lat_addr  (lat_addr),
        .lat_data  (lat_data)
    );

    flash_id_rom i_idrom (
        .sel_dev (addr[0]),
        .id_byte (id_byte)
    );

endmodule

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          hv_en = 1'b1, lockout = 1'b0, seq_done = 1'b0;
    logic          rd_id_sel, seq_start, seq_kind;
    logic [7:0]    id_byte, lat_data;
    logic [AW-1:0] lat_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    flash_cmd_if #(.AW(AW), .MIN_PULSE(2)) i_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .hv_en(hv_en), .lockout(lockout),
        .seq_done(seq_done), .rd_id_sel(rd_id_sel), .id_byte(id_byte),
        .seq_start(seq_start), .seq_kind(seq_kind),
        .lat_addr(lat_addr), .lat_data(lat_data)
    );

    // {command byte, expected rd_id_sel afterwards}
    localparam logic [8:0] VEC [0:7] = '{
        {8'h90, 1'b1}, {8'h00, 1'b0}, {8'h80, 1'b1}, {8'hFF, 1'b0},
        {8'h90, 1'b1}, {8'h42, 1'b0}, {8'h80, 1'b1}, {8'h80, 1'b1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Write strobe pulse of len clocks; returns on the clock where the
    // command register has taken the write into account.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d,
                      input int len, input logic oe);
        @(negedge clk);
        addr = a; din = d; oe_n = oe; ce_n = 1'b0; we_n = 1'b0;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic done_pulse();
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5 reset state
        chk("R5 reset rd_id_sel", 32'(rd_id_sel), 0);
        chk("R5 reset seq_start", 32'(seq_start), 0);
        chk("R8 reset lat_addr", 32'(lat_addr), 0);

        // R5 / R6 / R13 table walk
        for (int i = 0; i < 8; i++) begin
            wr(15'h0, VEC[i][8:1], 2, 1'b1);
            chk($sformatf("R5/R6/R13 table %0d", i), 32'(rd_id_sel), 32'(VEC[i][0]));
        end

        // R6 identifier codes
        @(negedge clk); addr = 15'h0; #1;
        chk("R6 maker code", 32'(id_byte), 32'h01);
        addr = 15'h1; #1;
        chk("R6 device code", 32'(id_byte), 32'h2F);
        wr(15'h0, 8'hFF, 2, 1'b1);
        chk("R5 back to array", 32'(rd_id_sel), 0);

        // R1 write with output enable low is ignored
        wr(15'h0, 8'h90, 3, 1'b0);
        chk("R1 oe low ignored", 32'(rd_id_sel), 0);

        // R4 glitch filter
        wr(15'h0, 8'h90, 1, 1'b1);
        chk("R4 short pulse dropped", 32'(rd_id_sel), 0);
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R4 minimum pulse accepted", 32'(rd_id_sel), 1);
        wr(15'h0, 8'h00, 2, 1'b1);

        // R7 erase
        wr(15'h0, 8'h30, 2, 1'b1);
        chk("R7 first 30h no start", 32'(seq_start), 0);
        wr(15'h7, 8'h30, 2, 1'b1);
        chk("R7 erase start", 32'(seq_start), 1);
        chk("R7 erase kind", 32'(seq_kind), 1);
        @(negedge clk);
        chk("R7 start one clock", 32'(seq_start), 0);

        // R12 busy ignores writes
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R12 busy ignores ident", 32'(rd_id_sel), 0);
        wr(15'h0, 8'h30, 2, 1'b1);
        wr(15'h0, 8'h30, 2, 1'b1);
        chk("R12 busy ignores erase", 32'(seq_start), 0);
        done_pulse();
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R12 accepted after done", 32'(rd_id_sel), 1);
        wr(15'h0, 8'h00, 2, 1'b1);

        // R8 program with 50h
        wr(15'h0, 8'h50, 2, 1'b1);
        wr(15'h1234, 8'hA5, 3, 1'b1);
        chk("R8 program start", 32'(seq_start), 1);
        chk("R8 program kind", 32'(seq_kind), 0);
        chk("R8 program addr", 32'(lat_addr), 32'h1234);
        chk("R8 program data", 32'(lat_data), 32'hA5);
        done_pulse();

        // R2 / R3 chip-select controlled write after 10h set-up
        wr(15'h0, 8'h10, 2, 1'b1);
        @(negedge clk); we_n = 1'b0; addr = 15'h0111; din = 8'h11;
        @(negedge clk); ce_n = 1'b0; addr = 15'h0222;
        @(negedge clk); addr = 15'h0333; din = 8'h3C;
        @(negedge clk); ce_n = 1'b1; din = 8'hEE;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk);
        chk("R8 program via 10h start", 32'(seq_start), 1);
        chk("R2 later falling edge address", 32'(lat_addr), 32'h0222);
        chk("R3 earlier rising edge data", 32'(lat_data), 32'h3C);
        done_pulse();

        // R9 mismatched second cycle
        wr(15'h0, 8'h30, 2, 1'b1);
        wr(15'h0, 8'h55, 2, 1'b1);
        chk("R9 mismatch no start", 32'(seq_start), 0);
        wr(15'h0, 8'h30, 2, 1'b1);
        chk("R9 sequence abandoned", 32'(seq_start), 0);
        wr(15'h0, 8'h00, 2, 1'b1);

        // R10 high voltage removed
        wr(15'h0, 8'h90, 2, 1'b1);
        @(negedge clk); hv_en = 1'b0;
        @(negedge clk);
        chk("R10 forced to array", 32'(rd_id_sel), 0);
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R10 write ignored", 32'(rd_id_sel), 0);
        hv_en = 1'b1;
        wr(15'h0, 8'h30, 2, 1'b1);
        @(negedge clk); hv_en = 1'b0;
        @(negedge clk); hv_en = 1'b1;
        wr(15'h0, 8'h30, 2, 1'b1);
        chk("R10 armed sequence lost", 32'(seq_start), 0);
        wr(15'h0, 8'h00, 2, 1'b1);

        // R11 lockout
        wr(15'h0, 8'h80, 2, 1'b1);
        @(negedge clk); lockout = 1'b1;
        @(negedge clk);
        chk("R11 forced to array", 32'(rd_id_sel), 0);
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R11 write ignored", 32'(rd_id_sel), 0);
        lockout = 1'b0;
        wr(15'h0, 8'h30, 2, 1'b1);
        wr(15'h0, 8'h30, 2, 1'b1);
        chk("R11 erase start before lockout", 32'(seq_start), 1);
        @(negedge clk); lockout = 1'b1;
        @(negedge clk); lockout = 1'b0;
        wr(15'h0, 8'h90, 2, 1'b1);
        chk("R11 busy cleared by lockout", 32'(rd_id_sel), 1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule